// File: doc/BRIEF.md
# Six-port reservation issue selector

This block is a small reservation station for an out-of-order core. Every micro-op it holds is already ready to run. Each micro-op carries an operation class, an age and an opaque payload. Each cycle the block picks at most one micro-op for each of six issue ports.

- Ports 0, 1 and 5 are the arithmetic ports, and they are not interchangeable: each class may issue only on a fixed set of ports.
- Port 2 takes loads, port 3 takes store addresses and port 4 takes store data.

Up to `ALLOC_N` micro-ops enter per cycle through parallel allocation lanes. An issued micro-op leaves the station at the next clock edge.

Selection works in two passes over the stored entries:

1. Classes that can use only one port claim that port first. On each port the oldest such entry wins.
2. Integer ALU and vector integer operations can use any arithmetic port. They then fill the arithmetic ports still free, visited in the order 0, 1, 5. The oldest of them goes to the lowest free port.

An entry picked on one port is hidden from every other port in the same cycle.

Top module: `rs_six_port_issue`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after its release, every `issue_valid_o` bit is 0 and `alloc_ready_o` is 1.
- R2: Each port issues at most one micro-op per cycle. A stored micro-op issues on at most one port per cycle, and only while it is held in the station.
- R3: Class code 8 (load) issues only on port 2. Code 9 (store address) issues only on port 3. Code 10 (store data) issues only on port 4.
- R4: Class code 2 (64-bit integer multiply) and code 3 (floating-point multiply, scalar or vector) issue only on port 0.
- R5: Class code 4 (shift, rotate or 32-bit multiply) and code 5 (floating-point add, scalar or vector) issue only on port 1.
- R6: Class code 6 (branch) and code 7 (vector shuffle) issue only on port 5.
- R7: Among the single-port entries eligible for a port, the smallest age wins. On equal ages, the lowest slot index wins. Single-port entries claim their port before any multi-port entry is considered.
- R8: Class code 0 (integer ALU) and code 1 (vector integer) fill the arithmetic ports left free by R7, visited in the order 0, 1, 5. The oldest remaining such entry takes each free port in turn. Ties are broken by the lowest slot index.
- R9: At most three integer or arithmetic micro-ops issue per cycle. Any further ready ones wait for a later cycle.
- R10: An issued micro-op is removed at the next clock edge and never issues again. Its slot can be refilled from that edge on.
- R11: `alloc_ready_o` is 1 exactly when at least `ALLOC_N` slots are free. While it is 0, allocation lanes are ignored.
- R12: When `alloc_ready_o` is 1, the j-th valid lane (in lane order) is written into the j-th lowest free slot. Its payload appears unchanged on its issue port, starting in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | ALLOC_N | Per-lane allocation request |
| alloc_class_i | input | ALLOC_N x 4 | Per-lane operation class code |
| alloc_age_i | input | ALLOC_N x AGE_W | Per-lane age; a smaller value is older |
| alloc_payload_i | input | ALLOC_N x PAY_W | Per-lane opaque payload |
| alloc_ready_o | output | 1 | Station can accept a full set of lanes this cycle |
| issue_valid_o | output | 6 | Per-port issue valid |
| issue_payload_o | output | 6 x PAY_W | Per-port payload of the issued micro-op |

## Verification
Issue outputs are combinational from the stored entries. A micro-op accepted at a rising edge is therefore visible on its port throughout the next cycle, and it is gone one edge after it issues. `alloc_ready_o` likewise reflects the occupancy left by the previous edge. The bench drives inputs and samples every output at the falling edge, comparing against a model that is advanced once per rising edge. Directed sequences then check specific ports exactly one and two cycles after an allocation, with no extra latency allowed.

// File: rtl/rs_issue_pkg.sv
package rs_issue_pkg;
  localparam int NUM_PORTS = 6;
  localparam int CLS_W     = 4;

  typedef enum logic [CLS_W-1:0] {
    OP_ALU    = 4'd0,
    OP_VINT   = 4'd1,
    OP_MUL64  = 4'd2,
    OP_FMUL   = 4'd3,
    OP_SHIFT  = 4'd4,
    OP_FADD   = 4'd5,
    OP_BRANCH = 4'd6,
    OP_SHUF   = 4'd7,
    OP_LOAD   = 4'd8,
    OP_STA    = 4'd9,
    OP_STD    = 4'd10
  } op_class_e;

  localparam logic [NUM_PORTS-1:0] ARITH_PORTS = 6'b100011;

  // eligible issue ports per class, bit p = port p
  function automatic logic [NUM_PORTS-1:0] class_ports(input logic [CLS_W-1:0] cls);
    logic [NUM_PORTS-1:0] m;
    case (op_class_e'(cls))
      OP_ALU, OP_VINT:    m = ARITH_PORTS;
      OP_MUL64, OP_FMUL:  m = 6'b000001;
      OP_SHIFT, OP_FADD:  m = 6'b000010;
      OP_BRANCH, OP_SHUF: m = 6'b100000;
      OP_LOAD:            m = 6'b000100;
      OP_STA:             m = 6'b001000;
      OP_STD:             m = 6'b010000;
      default:            m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/rs_class_decode.sv
module rs_class_decode
  import rs_issue_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0][CLS_W-1:0]     cls_i,
  output logic [NUM_PORTS-1:0][DEPTH-1:0] elig_o,
  output logic [DEPTH-1:0]                single_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [NUM_PORTS-1:0] m;
    assign m = class_ports(cls_i[i]);
    assign single_o[i] = $onehot(m);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign elig_o[p][i] = m[p];
    end
  end
endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
  parameter int DEPTH = 16,
  parameter int AGE_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]            req_i,
  input  logic [DEPTH-1:0][AGE_W-1:0] age_i,
  output logic [DEPTH-1:0]            gnt_o,
  output logic                        found_o
);
  logic [IDX_W-1:0] best;
  logic [AGE_W-1:0] best_age;

  // strict compare keeps the lowest index on equal ages
  always_comb begin
    found_o  = 1'b0;
    best     = '0;
    best_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (req_i[i] && (!found_o || age_i[i] < best_age)) begin
        found_o  = 1'b1;
        best     = IDX_W'(i);
        best_age = age_i[i];
      end
    end
    gnt_o = '0;
    if (found_o) gnt_o[best] = 1'b1;
  end
endmodule

// File: rtl/rs_slot_alloc.sv
module rs_slot_alloc #(
  parameter int DEPTH   = 16,
  parameter int ALLOC_N = 4,
  localparam int LANE_W = (ALLOC_N > 1) ? $clog2(ALLOC_N) : 1
) (
  input  logic [DEPTH-1:0]             valid_i,
  input  logic [ALLOC_N-1:0]           lane_valid_i,
  output logic                         ready_o,
  output logic [DEPTH-1:0]             wr_en_o,
  output logic [DEPTH-1:0][LANE_W-1:0] wr_lane_o
);
  logic [ALLOC_N-1:0][LANE_W-1:0] lane_of_rank;
  int nval;
  int nfree;
  int rank;
  int cnt;

  always_comb begin
    nval = 0;
    for (int k = 0; k < ALLOC_N; k++) if (lane_valid_i[k]) nval++;
    for (int r = 0; r < ALLOC_N; r++) begin
      lane_of_rank[r] = '0;
      cnt = 0;
      for (int k = 0; k < ALLOC_N; k++) begin
        if (lane_valid_i[k]) begin
          if (cnt == r) lane_of_rank[r] = LANE_W'(k);
          cnt++;
        end
      end
    end
    nfree = 0;
    for (int i = 0; i < DEPTH; i++) if (!valid_i[i]) nfree++;
    ready_o = (nfree >= ALLOC_N);
  end

  always_comb begin
    rank      = 0;
    wr_en_o   = '0;
    wr_lane_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_i[i]) begin
        for (int r = 0; r < ALLOC_N; r++) begin
          if (rank == r && r < nval && ready_o) begin
            wr_en_o[i]   = 1'b1;
            wr_lane_o[i] = lane_of_rank[r];
          end
        end
        rank++;
      end
    end
  end
endmodule

// File: rtl/rs_six_port_issue.sv
module rs_six_port_issue
  import rs_issue_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ALLOC_N = 4,
  parameter int AGE_W   = 8,
  parameter int PAY_W   = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [ALLOC_N-1:0]                  alloc_valid_i,
  input  logic [ALLOC_N-1:0][CLS_W-1:0]       alloc_class_i,
  input  logic [ALLOC_N-1:0][AGE_W-1:0]       alloc_age_i,
  input  logic [ALLOC_N-1:0][PAY_W-1:0]       alloc_payload_i,
  output logic                                alloc_ready_o,
  output logic [NUM_PORTS-1:0]                issue_valid_o,
  output logic [NUM_PORTS-1:0][PAY_W-1:0]     issue_payload_o
);
  localparam int LANE_W  = (ALLOC_N > 1) ? $clog2(ALLOC_N) : 1;
  localparam int N_ARITH = 3;

  logic [DEPTH-1:0]                 valid_q;
  logic [DEPTH-1:0][CLS_W-1:0]      cls_q;
  logic [DEPTH-1:0][AGE_W-1:0]      age_q;
  logic [DEPTH-1:0][PAY_W-1:0]      pay_q;

  logic [NUM_PORTS-1:0][DEPTH-1:0]  elig;
  logic [DEPTH-1:0]                 single;
  logic [DEPTH-1:0]                 multi;
  logic [NUM_PORTS-1:0][DEPTH-1:0]  gnt1;
  logic [NUM_PORTS-1:0]             any1;
  logic [N_ARITH-1:0][DEPTH-1:0]    gnt2;
  logic [N_ARITH-1:0]               any2;
  logic [N_ARITH:0][DEPTH-1:0]      taken;
  logic [NUM_PORTS-1:0][DEPTH-1:0]  gnt;
  logic [DEPTH-1:0]                 issued;
  logic [DEPTH-1:0]                 wr_en;
  logic [DEPTH-1:0][LANE_W-1:0]     wr_lane;

  rs_class_decode #(.DEPTH(DEPTH)) u_dec (
    .cls_i    (cls_q),
    .elig_o   (elig),
    .single_o (single)
  );

  assign multi = valid_q & ~single;

  // pass 1: single-port classes claim their port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_single
    rs_oldest_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_pick (
      .req_i   (valid_q & single & elig[p]),
      .age_i   (age_q),
      .gnt_o   (gnt1[p]),
      .found_o (any1[p])
    );
  end

  // pass 2: multi-port classes fill free arithmetic ports, low port first
  assign taken[0] = '0;
  for (genvar k = 0; k < N_ARITH; k++) begin : g_multi
    localparam int P = (k == 0) ? 0 : (k == 1) ? 1 : 5;
    logic [DEPTH-1:0] req;
    assign req = multi & elig[P] & ~taken[k] & {DEPTH{~any1[P]}};
    rs_oldest_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_pick (
      .req_i   (req),
      .age_i   (age_q),
      .gnt_o   (gnt2[k]),
      .found_o (any2[k])
    );
    assign taken[k+1] = taken[k] | gnt2[k];
  end

  always_comb begin
    gnt    = gnt1;
    gnt[0] = gnt1[0] | gnt2[0];
    gnt[1] = gnt1[1] | gnt2[1];
    gnt[5] = gnt1[5] | gnt2[2];
    issued = '0;
    for (int p = 0; p < NUM_PORTS; p++) issued |= gnt[p];
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      issue_valid_o[p]   = |gnt[p];
      issue_payload_o[p] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (gnt[p][i]) issue_payload_o[p] |= pay_q[i];
      end
    end
  end

  rs_slot_alloc #(.DEPTH(DEPTH), .ALLOC_N(ALLOC_N)) u_alloc (
    .valid_i      (valid_q),
    .lane_valid_i (alloc_valid_i),
    .ready_o      (alloc_ready_o),
    .wr_en_o      (wr_en),
    .wr_lane_o    (wr_lane)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      cls_q   <= '0;
      age_q   <= '0;
      pay_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        valid_q[i] <= (valid_q[i] & ~issued[i]) | wr_en[i];
        if (wr_en[i]) begin
          cls_q[i] <= alloc_class_i[wr_lane[i]];
          age_q[i] <= alloc_age_i[wr_lane[i]];
          pay_q[i] <= alloc_payload_i[wr_lane[i]];
        end
      end
    end
  end
endmodule

// File: rtl/rs_issue_checker.sv
module rs_issue_checker #(
  parameter int DEPTH = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   alloc_ready_o,
  input logic [5:0]             issue_valid_o,
  input logic [DEPTH-1:0]       valid_q,
  input logic [5:0][DEPTH-1:0]  gnt,
  input logic [DEPTH-1:0]       issued,
  input logic [DEPTH-1:0]       wr_en,
  input logic [DEPTH-1:0]       multi
);
  logic [DEPTH-1:0][5:0] per_entry;
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      for (int p = 0; p < 6; p++) per_entry[i][p] = gnt[p][i];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assert_one_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(per_entry[i]) <= 1);
  end

  assert_grant_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issued & ~valid_q) == '0);

  assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|issued) |=> ((valid_q & $past(issued) & ~$past(wr_en)) == '0));

  assert_full_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_ready_o && issue_valid_o == '0) |=> !alloc_ready_o);

  assert_steer_p5_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt[5] & multi) != '0) |-> (issue_valid_o[0] && issue_valid_o[1]));

  assert_steer_p1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt[1] & multi) != '0) |-> issue_valid_o[0]);
endmodule

bind rs_six_port_issue rs_issue_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .alloc_ready_o (alloc_ready_o),
  .issue_valid_o (issue_valid_o),
  .valid_q       (valid_q),
  .gnt           (gnt),
  .issued        (issued),
  .wr_en         (wr_en),
  .multi         (multi)
);

// File: tb/sim_rs_six_port_issue.sv
module sim_rs_six_port_issue;
  localparam int DEPTH = 16;
  localparam int AN    = 4;
  localparam int AW    = 8;
  localparam int PW    = 16;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [AN-1:0]           a_val = '0;
  logic [AN-1:0][3:0]      a_cls = '0;
  logic [AN-1:0][AW-1:0]   a_age = '0;
  logic [AN-1:0][PW-1:0]   a_pay = '0;
  logic                    ready;
  logic [5:0]              i_val;
  logic [5:0][PW-1:0]      i_pay;

  int n_chk = 0;
  int n_fail = 0;

  // model state
  bit m_v[DEPTH];
  int m_c[DEPTH];
  int m_a[DEPTH];
  int m_p[DEPTH];
  int exp_slot[6];
  int pay_ctr = 0;
  bit saw_full = 0;

  rs_six_port_issue #(.DEPTH(DEPTH), .ALLOC_N(AN), .AGE_W(AW), .PAY_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(a_val), .alloc_class_i(a_cls),
    .alloc_age_i(a_age), .alloc_payload_i(a_pay),
    .alloc_ready_o(ready), .issue_valid_o(i_val), .issue_payload_o(i_pay)
  );

  always #5ns clk = ~clk;

  function automatic logic [5:0] ref_ports(int c);
    case (c)
      0, 1:    return 6'b100011;
      2, 3:    return 6'b000001;
      4, 5:    return 6'b000010;
      6, 7:    return 6'b100000;
      8:       return 6'b000100;
      9:       return 6'b001000;
      10:      return 6'b010000;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic string port_tag(int p);
    case (p)
      0: return "R4";
      1: return "R5";
      5: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int free_cnt();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (!m_v[i]) n++;
    return n;
  endfunction

  task automatic calc_expect();
    bit taken[DEPTH];
    int ap[3] = '{0, 1, 5};
    for (int p = 0; p < 6; p++) begin
      exp_slot[p] = -1;
      for (int i = 0; i < DEPTH; i++)
        if (m_v[i] && ref_ports(m_c[i]) == (6'b1 << p) &&
            (exp_slot[p] < 0 || m_a[i] < m_a[exp_slot[p]])) exp_slot[p] = i;
    end
    for (int i = 0; i < DEPTH; i++) taken[i] = 0;
    for (int k = 0; k < 3; k++) begin
      int best = -1;
      if (exp_slot[ap[k]] >= 0) continue;
      for (int i = 0; i < DEPTH; i++)
        if (m_v[i] && (m_c[i] == 0 || m_c[i] == 1) && !taken[i] &&
            (best < 0 || m_a[i] < m_a[best])) best = i;
      if (best >= 0) begin
        exp_slot[ap[k]] = best;
        taken[best] = 1;
      end
    end
  endtask

  // compare at falling edge, advance model, wait one cycle
  task automatic cycle();
    bit rdy;
    int slot[AN];
    int j;
    calc_expect();
    rdy = (free_cnt() >= AN);
    if (!rdy) saw_full = 1;
    chk(ready == rdy, "R11", "alloc_ready", int'(ready), int'(rdy));
    for (int p = 0; p < 6; p++) begin
      chk(i_val[p] == (exp_slot[p] >= 0), "R2", $sformatf("valid port %0d", p),
          int'(i_val[p]), int'(exp_slot[p] >= 0));
      if (exp_slot[p] >= 0)
        chk(int'(i_pay[p]) == m_p[exp_slot[p]], port_tag(p),
            $sformatf("payload port %0d", p), int'(i_pay[p]), m_p[exp_slot[p]]);
    end
    j = 0;
    for (int i = 0; i < DEPTH && j < AN; i++) if (!m_v[i]) begin slot[j] = i; j++; end
    for (int p = 0; p < 6; p++) if (exp_slot[p] >= 0) m_v[exp_slot[p]] = 0;
    if (rdy) begin
      j = 0;
      for (int k = 0; k < AN; k++) if (a_val[k]) begin
        m_v[slot[j]] = 1; m_c[slot[j]] = int'(a_cls[k]);
        m_a[slot[j]] = int'(a_age[k]); m_p[slot[j]] = int'(a_pay[k]);
        j++;
      end
    end
    @(negedge clk);
  endtask

  task automatic set_lane(int k, int c, int age, int pay);
    a_val[k] = 1'b1; a_cls[k] = 4'(c); a_age[k] = AW'(age); a_pay[k] = PW'(pay);
  endtask

  task automatic idle();
    a_val = '0;
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    chk(i_val == '0, "R1", "issue valid in reset", int'(i_val), 0);
    chk(ready == 1'b1, "R1", "ready in reset", int'(ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(i_val == '0, "R1", "issue valid after reset", int'(i_val), 0);

    // R8 R9: four ALU ops, three arithmetic ports
    set_lane(0, 0, 5, 16'hA000); set_lane(1, 0, 3, 16'hA001);
    set_lane(2, 0, 7, 16'hA002); set_lane(3, 0, 1, 16'hA003);
    cycle(); idle();
    chk(i_pay[0] == 16'hA003, "R8", "oldest ALU to port 0", int'(i_pay[0]), 'hA003);
    chk(i_pay[1] == 16'hA001, "R8", "next ALU to port 1", int'(i_pay[1]), 'hA001);
    chk(i_pay[5] == 16'hA000, "R8", "third ALU to port 5", int'(i_pay[5]), 'hA000);
    cycle();
    chk(i_val == 6'b000001 && i_pay[0] == 16'hA002, "R9", "fourth ALU waits",
        int'(i_pay[0]), 'hA002);
    cycle();
    chk(i_val == '0, "R10", "no reissue", int'(i_val), 0);

    // R7: single-port classes claim first
    set_lane(0, 2, 9, 16'hB000); set_lane(1, 0, 1, 16'hB001);
    set_lane(2, 0, 2, 16'hB002); set_lane(3, 4, 8, 16'hB003);
    cycle(); idle();
    chk(i_pay[0] == 16'hB000, "R7", "mul64 owns port 0", int'(i_pay[0]), 'hB000);
    chk(i_pay[1] == 16'hB003, "R7", "shift owns port 1", int'(i_pay[1]), 'hB003);
    chk(i_pay[5] == 16'hB001, "R7", "ALU to port 5", int'(i_pay[5]), 'hB001);
    cycle();
    chk(i_pay[0] == 16'hB002, "R7", "remaining ALU to port 0", int'(i_pay[0]), 'hB002);
    cycle();

    // R7 tie on age; R12 lane order to slots
    a_val = '0;
    set_lane(1, 8, 4, 16'hC001); set_lane(3, 8, 4, 16'hC003);
    cycle(); idle();
    chk(i_pay[2] == 16'hC001, "R12", "first lane wins tie", int'(i_pay[2]), 'hC001);
    cycle();
    chk(i_pay[2] == 16'hC003, "R7", "second load next", int'(i_pay[2]), 'hC003);
    cycle();

    // R11: flood port 0
    for (int c = 0; c < 10; c++) begin
      for (int k = 0; k < AN; k++) begin set_lane(k, 3, c, pay_ctr); pay_ctr++; end
      cycle();
    end
    idle();
    chk(saw_full, "R11", "ready dropped when full", int'(saw_full), 1);
    repeat (20) cycle();

    // random mix
    for (int c = 0; c < 4000; c++) begin
      int pct = (c < 2000) ? 40 : 85;
      for (int k = 0; k < AN; k++) begin
        if (($urandom % 100) < pct) begin
          set_lane(k, $urandom % 11, $urandom % 16, pay_ctr); pay_ctr++;
        end else a_val[k] = 1'b0;
      end
      cycle();
    end
    idle();
    repeat (40) cycle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule